// File: doc/BRIEF.md
# Bit-Serial Charge-Sharing DAC Switch Sequencer

This block drives the four switches of a converter built from two equal capacitors: a working capacitor that is charged to the reference or to ground, and a holding capacitor that keeps the running result. A code of `CODE_W` bits arrives on a valid/ready input. Once it is accepted, the block first empties both capacitors. It then walks the code from its least significant bit up to its most significant bit. For each bit it charges the working capacitor from that bit, opens every switch for one cycle, and then joins the two capacitors so that they share their charge. Because the capacitors are equal, each sharing step halves the sum. After the last bit the held voltage equals code / 2^CODE_W of full scale.

In parallel, the block keeps a digital copy of the held voltage. This is a `CODE_W`-bit fraction of full scale, and it is updated at every sharing step as v = (v + bit·2^CODE_W) / 2. After the final step it equals the accepted code. Input rules: `in_ready` is high only while the block is idle. A code is taken on a cycle in which `in_valid` and `in_ready` are both high. While a conversion runs, `in_valid` is ignored, and the source has to hold or drop its request. Results are not back-pressured: `done` pulses for one cycle, and `level` stays valid until the next accepted code.

Top module: `crd_serial_seq`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle: all four switches open, `busy`=0, `done`=0, `in_ready`=1 and `level`=0. This holds even when `rst` arrives in the middle of a conversion.
- R2: In the cycle after a code is accepted, the block is in the emptying phase. Only `sw_gnd` and `sw_clear` are closed, `busy`=1, and `level` reads 0.
- R3: Bits are charged in the order bit 0 up to bit CODE_W-1. In the charging cycle of bit k, `sw_ref` is closed if code[k]=1 and `sw_gnd` is closed if code[k]=0. The other switches are open.
- R4: Each charging cycle is followed by exactly one cycle with all four switches open.
- R5: Each gap cycle is followed by a sharing cycle in which only `sw_share` is closed.
- R6: A conversion takes exactly CODE_W sharing cycles. `busy` is high for 3·CODE_W+1 cycles, starting the cycle after acceptance.
- R7: In the charging cycle of bit k, `level` equals (code mod 2^k)·2^(CODE_W-k). In the `done` cycle it equals the code.
- R8: `in_ready` is low whenever `busy` is high. A valid code presented during a conversion changes neither the switch sequence nor the result.
- R9: `sw_ref` and `sw_gnd` are never closed in the same cycle.
- R10: `done` is high for exactly one cycle, the one right after the last sharing cycle. `busy` is low in that cycle. `level` then holds its value until the next accepted code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Code request |
| in_ready | output | 1 | High while idle; a code is taken when both are high |
| in_code | input | CODE_W | Code to convert |
| sw_share | output | 1 | Joins working and holding capacitors |
| sw_ref | output | 1 | Ties working capacitor to the reference |
| sw_gnd | output | 1 | Ties working capacitor to ground |
| sw_clear | output | 1 | Ties holding capacitor to ground |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| level | output | CODE_W | Held voltage as a fraction of full scale |

## Verification
Internal faults show up at the ports as follows. A wrong bit index or a shift in the wrong direction makes the charging switch disagree with code[k] in the very cycle that bit is charged. It also leaves `level` off the expected partial value by the next charging cycle. A phase register that skips or repeats a state breaks the fixed charge/gap/share rhythm within one cycle, and it moves `done` away from cycle 3·CODE_W+2. A broken idle gate lets a second request restart the sequence, so the emptying pattern reappears in the middle of a conversion and the final `level` no longer matches the first code.

// File: rtl/crd_pkg.sv
package crd_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_EMPTY = 3'd1,
    PH_LOAD  = 3'd2,
    PH_GAP   = 3'd3,
    PH_SHARE = 3'd4
  } phase_t;

  typedef struct packed {
    logic share;
    logic to_ref;
    logic to_gnd;
    logic clear;
  } sw_t;

endpackage

// File: rtl/crd_phase_ctrl.sv
module crd_phase_ctrl
  import crd_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   start,
  output phase_t phase,
  output logic   done
);
  localparam int IDX_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CODE_W - 1);

  logic [IDX_W-1:0] bit_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      bit_idx <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_EMPTY;
            bit_idx <= '0;
          end
        end
        PH_EMPTY: phase <= PH_LOAD;
        PH_LOAD:  phase <= PH_GAP;
        PH_GAP:   phase <= PH_SHARE;
        PH_SHARE: begin
          if (bit_idx == LAST_IDX) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            bit_idx <= bit_idx + 1'b1;
            phase   <= PH_LOAD;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/crd_sw_decode.sv
module crd_sw_decode
  import crd_pkg::*;
(
  input  phase_t phase,
  input  logic   cur_bit,
  output sw_t    sw
);
  always_comb begin
    sw = '0;
    unique case (phase)
      PH_EMPTY: begin
        sw.to_gnd = 1'b1;
        sw.clear  = 1'b1;
      end
      PH_LOAD: begin
        if (cur_bit) sw.to_ref = 1'b1;
        else         sw.to_gnd = 1'b1;
      end
      PH_SHARE: sw.share = 1'b1;
      default: sw = '0;
    endcase
  end

endmodule

// File: rtl/crd_charge_model.sv
module crd_charge_model #(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              step,
  output logic              cur_bit,
  output logic [CODE_W-1:0] level
);
  logic [CODE_W-1:0] pend;

  assign cur_bit = pend[0];

  always_ff @(posedge clk) begin
    if (rst)       pend <= '0;
    else if (load) pend <= code;
    else if (step) pend <= pend >> 1;
  end

  // (v + b*2^W) / 2 is the new bit entering at the top over v shifted down
  generate
    if (CODE_W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)       level <= '0;
        else if (load) level <= '0;
        else if (step) level <= pend;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)       level <= '0;
        else if (load) level <= '0;
        else if (step) level <= {pend[0], level[CODE_W-1:1]};
      end
    end
  endgenerate

endmodule

// File: rtl/crd_serial_seq.sv
module crd_serial_seq
  import crd_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CODE_W-1:0] in_code,
  output logic              sw_share,
  output logic              sw_ref,
  output logic              sw_gnd,
  output logic              sw_clear,
  output logic              busy,
  output logic              done,
  output logic [CODE_W-1:0] level
);
  phase_t phase;
  sw_t    sw;
  logic   start;
  logic   cur_bit;

  assign in_ready = (phase == PH_IDLE);
  assign busy     = ~in_ready;
  assign start    = in_valid & in_ready;

  crd_phase_ctrl #(.CODE_W(CODE_W)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .phase (phase),
    .done  (done)
  );

  crd_charge_model #(.CODE_W(CODE_W)) u_model (
    .clk     (clk),
    .rst     (rst),
    .load    (start),
    .code    (in_code),
    .step    (phase == PH_SHARE),
    .cur_bit (cur_bit),
    .level   (level)
  );

  crd_sw_decode u_dec (
    .phase   (phase),
    .cur_bit (cur_bit),
    .sw      (sw)
  );

  assign sw_share = sw.share;
  assign sw_ref   = sw.to_ref;
  assign sw_gnd   = sw.to_gnd;
  assign sw_clear = sw.clear;

endmodule

// File: rtl/crd_serial_seq_chk.sv
module crd_serial_seq_chk #(
  parameter int CODE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [CODE_W-1:0] in_code,
  input logic              sw_share,
  input logic              sw_ref,
  input logic              sw_gnd,
  input logic              sw_clear,
  input logic              busy,
  input logic              done,
  input logic [CODE_W-1:0] level
);
  logic [CODE_W-1:0] taken;

  always_ff @(posedge clk) begin
    if (rst) taken <= '0;
    else if (in_valid && in_ready) taken <= in_code;
  end

  // R9
  ref_gnd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sw_ref && sw_gnd));

  // R2
  empty_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> (sw_gnd && sw_clear && !sw_ref && !sw_share && busy));

  // R4
  gap_after_load_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_ref || (sw_gnd && !sw_clear)) |=> !(sw_share || sw_ref || sw_gnd || sw_clear));

  // R5
  share_alone_chk: assert property (@(posedge clk) disable iff (rst)
    sw_share |-> !(sw_ref || sw_gnd || sw_clear));

  // R8
  no_ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !in_ready);

  // R1
  idle_open_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(sw_share || sw_ref || sw_gnd || sw_clear));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  final_level_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (level == taken));

endmodule

bind crd_serial_seq crd_serial_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_code  (in_code),
  .sw_share (sw_share),
  .sw_ref   (sw_ref),
  .sw_gnd   (sw_gnd),
  .sw_clear (sw_clear),
  .busy     (busy),
  .done     (done),
  .level    (level)
);

// File: tb/crd_serial_seq_bench.sv
`timescale 1ns/1ps
module crd_serial_seq_bench;
  localparam int N = 8;
  localparam int NVEC = 8;
  localparam logic [N-1:0] VEC [NVEC] = '{8'h00, 8'hFF, 8'h05, 8'hA5,
                                          8'h80, 8'h01, 8'h5A, 8'h3C};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N-1:0] in_code = '0;
  logic in_ready, sw_share, sw_ref, sw_gnd, sw_clear, busy, done;
  logic [N-1:0] level;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  crd_serial_seq #(.CODE_W(N)) u_crd_serial_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_code(in_code), .sw_share(sw_share), .sw_ref(sw_ref), .sw_gnd(sw_gnd),
    .sw_clear(sw_clear), .busy(busy), .done(done), .level(level)
  );

  function automatic logic [3:0] sw_now();
    return {sw_share, sw_ref, sw_gnd, sw_clear};
  endfunction

  function automatic logic [N-1:0] partial(input logic [N-1:0] code, input int k);
    logic [2*N-1:0] t;
    t = (2*N)'(code) & (((2*N)'(1)) << k) - 1;
    t = t << (N - k);
    return t[N-1:0];
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one full conversion; poke keeps a different request up while busy
  task automatic run_conv(input logic [N-1:0] code, input bit poke);
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = code;
    @(negedge clk);
    in_valid = poke;
    in_code  = ~code;
    chk(sw_now() == 4'b0011, "R2", "empty switches", sw_now(), 4'b0011);
    chk(busy && level == '0, "R2", "busy/level at empty", {busy, level}, {1'b1, 8'h00});
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      chk(sw_now() == (code[k] ? 4'b0100 : 4'b0010), "R3", "charge switches",
          sw_now(), code[k] ? 4'b0100 : 4'b0010);
      chk(!(sw_ref && sw_gnd), "R9", "ref/gnd exclusive", sw_now(), 0);
      chk(level == partial(code, k), "R7", "partial level", level, partial(code, k));
      chk(!in_ready, "R8", "ready while busy", in_ready, 0);
      @(negedge clk);
      chk(sw_now() == 4'b0000, "R4", "gap switches", sw_now(), 0);
      @(negedge clk);
      chk(sw_now() == 4'b1000, "R5", "share switches", sw_now(), 4'b1000);
      chk(busy, "R6", "busy through last share", busy, 1);
      if (k == N - 1) in_valid = 1'b0;
    end
    @(negedge clk);
    chk(done && !busy, "R6", "done/busy after last share", {done, busy}, 2'b10);
    chk(level == code, "R7", "final level", level, code);
    chk(sw_now() == 4'b0000, "R10", "switches open at done", sw_now(), 0);
    @(negedge clk);
    chk(!done, "R10", "done single cycle", done, 0);
    chk(level == code, "R10", "level holds", level, code);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(sw_now() == 4'b0000, "R1", "reset switches", sw_now(), 0);
    chk(!busy && in_ready && !done, "R1", "reset flags", {busy, in_ready, done}, 3'b010);
    chk(level == '0, "R1", "reset level", level, 0);

    // table walk: final level equals code, sequence follows bits LSB first
    for (int i = 0; i < NVEC; i++) run_conv(VEC[i], 1'b0);

    // request held high during a conversion is ignored (R8)
    run_conv(8'h96, 1'b1);
    chk(level == 8'h96, "R8", "result after ignored request", level, 8'h96);

    // level holds while idle (R10)
    repeat (10) @(negedge clk);
    chk(level == 8'h96 && !busy, "R10", "level hold idle", level, 8'h96);

    // reset in mid conversion (R1)
    @(negedge clk);
    in_valid = 1'b1;
    in_code  = 8'h7E;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (6) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(sw_now() == 4'b0000 && !busy, "R1", "mid reset idle", {sw_now(), busy}, 0);
    chk(level == '0 && in_ready, "R1", "mid reset level", level, 0);

    // conversion after mid reset still exact (R6)
    run_conv(8'h81, 1'b0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule